// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port with Serial-Link Pin Takeover

This block is an eight-pin bidirectional I/O port for a pad ring. Software sets a direction register and a port register through two write strobes sharing one data bus, and reads both back together with a synchronized copy of the pad levels. A single global input turns off every pull-up at once. For each pin the block drives three pad controls: output enable, output level and pull-up enable.

An attached SPI peripheral can claim the upper four pins, with the master/slave mode deciding the role of each. In slave mode the clock, master-out data and select pins are forced to inputs. In master mode the master-in data pin is forced to an input. On a pin the SPI drives, the level comes from the SPI instead of the port register. On a forced input the port bit still sets the pull-up.

The block also gives the peripheral a synchronized slave-select-active flag. A power-down input blanks the digital read path of the two comparator pins, so analog levels on them do not toggle logic.

Top module: `gpio_spi_port`

## Requirements
- R1: While reset is asserted, and right after it, the direction register, the port register and the pin read value are all 0. Every pad output enable and pull-up enable is 0.
- R2: A high `wr_dir` loads `wdata` into the direction register at the clock edge. A high `wr_port` loads `wdata` into the port register at the clock edge. Both registers read back on `rd_dir` and `rd_port` after that edge.
- R3: With the SPI disabled, a pin whose direction bit is 1 has output enable 1, output level equal to its port bit, and pull-up 0. The mode input `spi_master` has no effect.
- R4: A pin whose output enable is 0 has output level 0. Its pull-up is on exactly when its port bit is 1 and `pu_disable` is 0.
- R5: With the SPI enabled and `spi_master` at 0 (slave), pins 7, 5 and 4 have output enable 0 whatever their direction bits. Pin 6 follows its direction bit, and when enabled it drives `spi_miso_o`.
- R6: With the SPI enabled and `spi_master` at 1, pin 6 has output enable 0 whatever its direction bit. Pins 7, 5 and 4 follow their direction bits. When enabled, pin 7 drives `spi_sck_o`, pin 5 drives `spi_mosi_o` and pin 4 drives its port bit.
- R7: A pin forced to an input by the SPI keeps its pull-up set by its port bit, gated by `pu_disable`.
- R8: A level applied on `pad_in` before clock edge k appears on `rd_pin` after edge k+1, which is two edges later.
- R9: While `power_down` is 1, `rd_pin[3:2]` reads 0. After it drops, those bits show the pad again once two edges have captured it.
- R10: `spi_ss_active` is the inverse of the synchronized pin 4 value. It reads 1 while that value is 0, including after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_dir | input | 1 | Direction register write strobe |
| wr_port | input | 1 | Port register write strobe |
| wdata | input | 8 | Write data |
| pu_disable | input | 1 | Global pull-up disable |
| spi_en | input | 1 | SPI peripheral enabled |
| spi_master | input | 1 | SPI mode, 1 = master |
| spi_sck_o | input | 1 | SPI clock level to drive in master mode |
| spi_mosi_o | input | 1 | SPI master-out level to drive in master mode |
| spi_miso_o | input | 1 | SPI master-in level to drive in slave mode |
| power_down | input | 1 | Power-down, blanks pins 3:2 input path |
| pad_in | input | 8 | Raw pad input levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_do | output | 8 | Per-pin output level |
| pad_pu | output | 8 | Per-pin pull-up enable |
| rd_dir | output | 8 | Direction register readback |
| rd_port | output | 8 | Port register readback |
| rd_pin | output | 8 | Synchronized pin values |
| spi_ss_active | output | 1 | Synchronized slave select active |

## Verification
The pad controls are combinational from the registers and SPI inputs. They are checked one time unit after the inputs change, in the same cycle. Register writes are checked at the next falling edge after the write edge. `rd_pin` and `spi_ss_active` are compared against the pad value applied two iterations earlier. The two power-down bits are zeroed if power-down was high when that value was captured or is high now. Each iteration applies stimulus at the falling edge, and the bench keeps a two-deep history of pad and power-down values so every check samples at the cycle its result is due.

// File: rtl/gpio_spi_pkg.sv
package gpio_spi_pkg;
  localparam int unsigned NPINS    = 8;
  localparam int unsigned SYNC_LEN = 2;
  localparam int unsigned B_CLK    = 7;
  localparam int unsigned B_MISO   = 6;
  localparam int unsigned B_MOSI   = 5;
  localparam int unsigned B_SEL    = 4;
  localparam int unsigned B_CMPN   = 3;
  localparam int unsigned B_CMPP   = 2;
  localparam logic [NPINS-1:0] CMP_MASK = (1 << B_CMPN) | (1 << B_CMPP);

  typedef enum logic [1:0] {
    SRC_PORT = 2'd0,
    SRC_SCK  = 2'd1,
    SRC_MOSI = 2'd2,
    SRC_MISO = 2'd3
  } out_src_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] GATE_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         gate,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] dout_raw
);
  logic [W-1:0] st1_q, st2_q, st1_d, st2_d;
  logic [W-1:0] keep;

  always_comb begin
    keep  = gate ? ~GATE_MASK : '1;
    st1_d = din & keep;
    st2_d = st1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_q <= '0;
      st2_q <= '0;
    end else begin
      st1_q <= st1_d;
      st2_q <= st2_d;
    end
  end

  assign dout     = st2_q & keep;
  assign dout_raw = st2_q;
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_spi_pkg::*;
#(
  parameter int unsigned IDX = 0
) (
  input  logic dir_bit,
  input  logic port_bit,
  input  logic pu_disable,
  input  logic spi_en,
  input  logic spi_master,
  input  logic sck_lvl,
  input  logic mosi_lvl,
  input  logic miso_lvl,
  output logic oe,
  output logic dout,
  output logic pu
);
  logic     forced_in;
  out_src_e src;
  logic     lvl;

  always_comb begin
    forced_in = 1'b0;
    src       = SRC_PORT;
    if (spi_en) begin
      if (spi_master) begin
        forced_in = (IDX == B_MISO);
        if (IDX == B_CLK)  src = SRC_SCK;
        if (IDX == B_MOSI) src = SRC_MOSI;
      end else begin
        forced_in = (IDX == B_CLK) || (IDX == B_MOSI) || (IDX == B_SEL);
        if (IDX == B_MISO) src = SRC_MISO;
      end
    end
    case (src)
      SRC_SCK:  lvl = sck_lvl;
      SRC_MOSI: lvl = mosi_lvl;
      SRC_MISO: lvl = miso_lvl;
      default:  lvl = port_bit;
    endcase
    oe   = dir_bit & ~forced_in;
    dout = oe & lvl;
    pu   = ~oe & port_bit & ~pu_disable;
  end
endmodule

// File: rtl/gpio_spi_port.sv
module gpio_spi_port
  import gpio_spi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_dir,
  input  logic             wr_port,
  input  logic [NPINS-1:0] wdata,
  input  logic             pu_disable,
  input  logic             spi_en,
  input  logic             spi_master,
  input  logic             spi_sck_o,
  input  logic             spi_mosi_o,
  input  logic             spi_miso_o,
  input  logic             power_down,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_do,
  output logic [NPINS-1:0] pad_pu,
  output logic [NPINS-1:0] rd_dir,
  output logic [NPINS-1:0] rd_port,
  output logic [NPINS-1:0] rd_pin,
  output logic             spi_ss_active
);
  logic             rst_q_n;
  logic [NPINS-1:0] dir_q, dir_d, port_q, port_d;
  logic [NPINS-1:0] pin_raw;

  gpio_rst_sync #(.STAGES(SYNC_LEN)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n)
  );

  always_comb begin
    dir_d  = wr_dir  ? wdata : dir_q;
    port_d = wr_port ? wdata : port_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      dir_q  <= '0;
      port_q <= '0;
    end else begin
      dir_q  <= dir_d;
      port_q <= port_d;
    end
  end

  gpio_in_sync #(.W(NPINS), .GATE_MASK(CMP_MASK)) u_sync (
    .clk(clk), .rst_n(rst_q_n), .gate(power_down),
    .din(pad_in), .dout(rd_pin), .dout_raw(pin_raw)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    gpio_pin_ctrl #(.IDX(g)) u_pin (
      .dir_bit(dir_q[g]), .port_bit(port_q[g]), .pu_disable(pu_disable),
      .spi_en(spi_en), .spi_master(spi_master),
      .sck_lvl(spi_sck_o), .mosi_lvl(spi_mosi_o), .miso_lvl(spi_miso_o),
      .oe(pad_oe[g]), .dout(pad_do[g]), .pu(pad_pu[g])
    );
  end

  assign rd_dir        = dir_q;
  assign rd_port       = port_q;
  assign spi_ss_active = ~pin_raw[B_SEL];
endmodule

// File: rtl/gpio_spi_port_chk.sv
module gpio_spi_port_chk
  import gpio_spi_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_dir,
  input logic             wr_port,
  input logic [NPINS-1:0] wdata,
  input logic             pu_disable,
  input logic             spi_en,
  input logic             spi_master,
  input logic             power_down,
  input logic [NPINS-1:0] pad_in,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_pu,
  input logic [NPINS-1:0] rd_dir,
  input logic [NPINS-1:0] rd_port,
  input logic [NPINS-1:0] rd_pin
);
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age_q <= '0;
    else if (age_q != 2) age_q <= age_q + 2'd1;
  end

  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> rd_dir == $past(wdata));
  a_r2_port_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_port |=> rd_port == $past(wdata));
  a_r4_no_pull_on_output: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_pu) == '0);
  a_r5_slave_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && !spi_master) |-> (!pad_oe[B_CLK] && !pad_oe[B_MOSI] && !pad_oe[B_SEL]));
  a_r6_master_miso_in: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && spi_master) |-> !pad_oe[B_MISO]);
  a_r7_forced_pull: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && spi_master) |-> pad_pu[B_MISO] == (rd_port[B_MISO] & ~pu_disable));
  a_r8_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2) |-> (rd_pin[7:4] == $past(pad_in[7:4], 2) &&
                      rd_pin[1:0] == $past(pad_in[1:0], 2)));
  a_r9_pd_blank: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |-> rd_pin[B_CMPN:B_CMPP] == 2'b00);
endmodule

bind gpio_spi_port gpio_spi_port_chk u_chk (
  .clk(clk), .rst_n(rst_q_n), .wr_dir(wr_dir), .wr_port(wr_port),
  .wdata(wdata), .pu_disable(pu_disable), .spi_en(spi_en),
  .spi_master(spi_master), .power_down(power_down), .pad_in(pad_in),
  .pad_oe(pad_oe), .pad_pu(pad_pu), .rd_dir(rd_dir), .rd_port(rd_port),
  .rd_pin(rd_pin)
);

// File: tb/gpio_spi_port_test.sv
module gpio_spi_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int ITERS = 3000;

  logic clk = 1'b0;
  logic rst_n, wr_dir, wr_port, pu_disable, spi_en, spi_master;
  logic spi_sck_o, spi_mosi_o, spi_miso_o, power_down;
  logic [7:0] wdata, pad_in, pad_oe, pad_do, pad_pu, rd_dir, rd_port, rd_pin;
  logic spi_ss_active;
  int total = 0, bad = 0;
  logic finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_spi_port uut (.*);

  task automatic chk(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  // expected pad controls: {oe, do, pu}
  function automatic logic [23:0] model(input logic [7:0] d, input logic [7:0] p,
      input logic pud, input logic en, input logic ms,
      input logic sck, input logic mosi, input logic miso);
    logic [7:0] oe, dv, pu;
    for (int i = 0; i < 8; i++) begin
      logic f, v;
      f = en && ((!ms && (i == 7 || i == 5 || i == 4)) || (ms && i == 6));
      oe[i] = d[i] && !f;
      v = p[i];
      if (en && ms && i == 7) v = sck;
      if (en && ms && i == 5) v = mosi;
      if (en && !ms && i == 6) v = miso;
      dv[i] = oe[i] && v;
      pu[i] = !oe[i] && p[i] && !pud;
    end
    return {oe, dv, pu};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=00 expected=01");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] m_dir, m_port, h1_pad, h2_pad, exp_pin;
    logic h1_pd, h2_pd, cur_pd;
    logic [23:0] e;
    string rq, rp;
    void'($urandom(32'h5EED_1234));
    rst_n = 0; wr_dir = 0; wr_port = 0; wdata = 0; pu_disable = 0;
    spi_en = 0; spi_master = 0; spi_sck_o = 0; spi_mosi_o = 0; spi_miso_o = 0;
    power_down = 0; pad_in = 8'hA5;
    repeat (3) @(negedge clk);
    chk(rd_dir == 0, "R1", rd_dir, 0);
    chk(rd_port == 0, "R1", rd_port, 0);
    chk(rd_pin == 0, "R1", rd_pin, 0);
    chk(pad_oe == 0, "R1", pad_oe, 0);
    chk(pad_pu == 0, "R1", pad_pu, 0);
    chk(spi_ss_active == 1'b1, "R10", {7'd0, spi_ss_active}, 8'h01);
    pad_in = 8'h00;
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(rd_dir == 0 && rd_port == 0 && rd_pin == 0, "R1", rd_pin, 0);
    m_dir = 0; m_port = 0; h1_pad = 0; h2_pad = 0; h1_pd = 0; h2_pd = 0; cur_pd = 0;
    for (int j = 0; j < ITERS; j++) begin
      @(negedge clk);
      exp_pin = h2_pad;
      if (h2_pd || cur_pd) exp_pin[3:2] = 2'b00;
      chk(rd_pin == exp_pin, (h2_pd || cur_pd) ? "R9" : "R8", rd_pin, exp_pin);
      chk(spi_ss_active == ~h2_pad[4], "R10", {7'd0, spi_ss_active}, {7'd0, ~h2_pad[4]});
      chk(rd_dir == m_dir, "R2", rd_dir, m_dir);
      chk(rd_port == m_port, "R2", rd_port, m_port);
      // stimulus: directed opening, then random
      if (j < 4) begin
        wr_dir = (j == 0); wr_port = (j == 1);
        wdata = (j == 0) ? 8'hFF : 8'hF0;
        pu_disable = (j == 3); spi_en = (j >= 2); spi_master = (j == 2);
        spi_sck_o = 1; spi_mosi_o = 1; spi_miso_o = 1;
        power_down = (j == 3); pad_in = 8'hFF;
      end else begin
        wr_dir = ($urandom % 4) == 0;
        wr_port = ($urandom % 4) == 0;
        wdata = 8'($urandom);
        pu_disable = ($urandom % 3) == 0;
        spi_en = $urandom % 2;
        spi_master = $urandom % 2;
        spi_sck_o = $urandom % 2; spi_mosi_o = $urandom % 2; spi_miso_o = $urandom % 2;
        power_down = ($urandom % 4) == 0;
        pad_in = 8'($urandom);
      end
      #1;
      e = model(m_dir, m_port, pu_disable, spi_en, spi_master, spi_sck_o, spi_mosi_o, spi_miso_o);
      rq = !spi_en ? "R3" : (spi_master ? "R6" : "R5");
      rp = spi_en ? "R7" : "R4";
      chk(pad_oe == e[23:16], rq, pad_oe, e[23:16]);
      chk(pad_do == e[15:8], rq, pad_do, e[15:8]);
      chk(pad_pu == e[7:0], rp, pad_pu, e[7:0]);
      if (wr_dir) m_dir = wdata;
      if (wr_port) m_port = wdata;
      h2_pad = h1_pad; h2_pd = h1_pd;
      h1_pad = pad_in; h1_pd = power_down; cur_pd = power_down;
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule